// File: doc/BRIEF.md
# SMM Entry and Interrupt Arbitration Controller

This block tracks whether the processor core is in system-management mode (SMM) and decides, cycle by cycle, which pending event is delivered: a system-management interrupt (SMI), a non-maskable interrupt (NMI) or a maskable interrupt (INTR). An accepted SMI produces a one-cycle acknowledge with the entry vector, which is the programmed SMM region base. A nested-status bit goes with each acknowledge, so the core can record it in its saved header. A depth counter lets resumes unwind nested sessions one level at a time.

Software writes a region base and a power-of-two size, given as its base-2 logarithm. The block checks these values and refuses SMI entry while they are illegal. Inside SMM, a further SMI is either held or accepted at once, as a nesting control bit selects. NMIs are delivered only when an NMI-enable bit allows it. Otherwise one NMI is kept for later. Maskable interrupts are gated by an internal interrupt flag. SMI entry clears that flag, a strobe sets it, and leaving the outermost session restores the value it had at entry.

All decisions are taken from the inputs of one cycle. The pulses and status they cause are visible after the next rising clock edge.

Top module: `smm_ctrl`

## Requirements
- R1: `cfg_err` is high, combinationally, when `size_log` is below 12 or above 25, or when `smm_base` is not a multiple of 2^`size_log`.
- R2: Outside SMM, with a legal configuration, an `smi_req` strobe gives `smi_ack`=1, `smi_vec`=`smm_base`, `nest_flag`=0 and `in_smm`=1 after the next edge.
- R3: With `nest_en` low, an SMI requested inside SMM is held without acknowledge. It is acknowledged in the cycle after the resume that leaves SMM.
- R4: With `nest_en` high, an SMI requested inside SMM is acknowledged after the next edge with `nest_flag`=1.
- R5: Each `rsm` inside SMM lowers the nesting depth by one. `in_smm` stays high until the resume that takes the depth to zero.
- R6: SMI entry clears the interrupt flag. `intr_dlv` pulses only when `intr_lvl` is high and the flag is set, and a delivery clears the flag. An `if_set` strobe sets the flag, and the flag first takes effect in the following cycle.
- R7: Inside SMM with `nmi_en` low, an NMI edge is latched, not delivered. Raising `nmi_en` delivers it after the next edge, exactly once.
- R8: A latched NMI is delivered in the cycle after the resume that leaves SMM. Further NMI edges that arrive while one is latched are dropped.
- R9: When a held SMI and a latched NMI are both pending after the exiting resume, the SMI is acknowledged first and the NMI stays latched.
- R10: While `cfg_err` is high, no SMI is acknowledged. The request is held and is acknowledged once the configuration is legal.
- R11: At the maximum depth of 15, further SMIs are held until a resume makes room.
- R12: The resume that leaves SMM restores the interrupt flag to the value it had when the outermost SMI was accepted.
- R13: Outside SMM, an NMI edge is delivered after the next edge. In the same cycle it takes priority over a maskable interrupt, which is delivered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req | input | 1 | External SMI request strobe |
| rsm | input | 1 | Resume strobe from the core |
| nest_en | input | 1 | Allow SMIs to nest inside SMM |
| nmi_edge | input | 1 | NMI edge strobe |
| nmi_en | input | 1 | Allow NMI delivery inside SMM |
| intr_lvl | input | 1 | Maskable interrupt request level |
| if_set | input | 1 | Strobe that sets the interrupt flag |
| smm_base | input | 32 | SMM region base address |
| size_log | input | 5 | log2 of the SMM region size in bytes |
| cfg_err | output | 1 | Illegal base/size configuration |
| in_smm | output | 1 | Core is in SMM |
| smi_ack | output | 1 | SMI accepted (one-cycle pulse) |
| smi_vec | output | 32 | Entry vector of the last accepted SMI |
| nest_flag | output | 1 | Nested status of the last accepted SMI |
| nmi_dlv | output | 1 | NMI delivered (one-cycle pulse) |
| intr_dlv | output | 1 | Maskable interrupt delivered (one-cycle pulse) |

## Verification
The assertions check on every cycle that:
- no acknowledge follows a cycle with an illegal configuration, or a cycle inside SMM with nesting off;
- each acknowledge leaves the block in SMM, carries the base as its vector, and reports nested status equal to the previous SMM state;
- NMI and INTR deliveries never coincide, and an INTR delivery never coincides with an acknowledge.

Only the bench scenarios can show:
- the ordering after an exiting resume: a held SMI goes before a latched NMI, and the NMI follows once SMM has been left;
- that extra NMI edges collapse into a single delivery;
- the unwinding of fifteen nested levels;
- the interrupt flag coming back to its value from before entry.

// File: rtl/smm_pkg.sv
package smm_pkg;
  // Per-cycle sequencing decision shared by the nesting and interrupt units.
  typedef struct packed {
    logic acc;         // an SMI is accepted this cycle
    logic first_entry; // the accepted SMI enters from normal mode
    logic rsm_any;     // a resume is consumed this cycle
    logic exit_smm;    // the consumed resume leaves SMM
  } smm_ev_t;
endpackage

// File: rtl/smm_cfg_check.sv
module smm_cfg_check #(
  parameter int ADDR_W  = 32,
  parameter int SZ_W    = 5,
  parameter int MIN_LOG = 12,
  parameter int MAX_LOG = 25
) (
  input  logic [ADDR_W-1:0] smm_base,
  input  logic [SZ_W-1:0]   size_log,
  output logic              cfg_err
);
  logic [ADDR_W-1:0] low_mask;

  // Mask of the address bits that lie below the region size.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign low_mask[i] = (32'(i) < 32'(size_log));
  end

  logic range_bad;
  logic misalign;

  assign range_bad = (32'(size_log) < 32'(MIN_LOG)) || (32'(size_log) > 32'(MAX_LOG));
  assign misalign  = |(smm_base & low_mask);
  assign cfg_err   = range_bad | misalign;
endmodule

// File: rtl/smm_nest_seq.sv
module smm_nest_seq
  import smm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_req,
  input  logic              rsm,
  input  logic              nest_en,
  input  logic              cfg_err,
  input  logic [ADDR_W-1:0] smm_base,
  output smm_ev_t           ev,
  output logic              in_smm,
  output logic              smi_ack,
  output logic [ADDR_W-1:0] smi_vec,
  output logic              nest_flag
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               held_q, held_d;
  logic               ack_d, nflag_d;
  logic               req, rsm_eff, acc, room;

  always_comb begin
    req     = smi_req | held_q;
    rsm_eff = rsm & (depth_q != '0);
    room    = (depth_q == '0) | (nest_en & (depth_q != DEPTH_MAX));
    acc     = req & ~cfg_err & room & ~rsm_eff;
    held_d  = req & ~acc;
    ack_d   = acc;
    nflag_d = acc ? (depth_q != '0) : nest_flag;
    if (acc)          depth_d = depth_q + DEPTH_ONE;
    else if (rsm_eff) depth_d = depth_q - DEPTH_ONE;
    else              depth_d = depth_q;
    ev.acc         = acc;
    ev.first_entry = acc & (depth_q == '0);
    ev.rsm_any     = rsm_eff;
    ev.exit_smm    = rsm_eff & (depth_q == DEPTH_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q   <= '0;
      held_q    <= 1'b0;
      smi_ack   <= 1'b0;
      nest_flag <= 1'b0;
    end else begin
      depth_q   <= depth_d;
      held_q    <= held_d;
      smi_ack   <= ack_d;
      nest_flag <= nflag_d;
    end
  end

  // Vector register loads only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   smi_vec <= '0;
    else if (acc) smi_vec <= smm_base;
  end

  assign in_smm = (depth_q != '0);
endmodule

// File: rtl/smm_irq_gate.sv
module smm_irq_gate
  import smm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  smm_ev_t ev,
  input  logic    in_smm,
  input  logic    nmi_edge,
  input  logic    nmi_en,
  input  logic    intr_lvl,
  input  logic    if_set,
  output logic    nmi_dlv,
  output logic    intr_dlv
);
  logic nmi_lat_q, nmi_lat_d;
  logic if_q, if_d;
  logic if_save_q, if_save_d;
  logic nmi_ok, nmi_src, nmi_d, intr_d;

  always_comb begin
    nmi_ok    = (~in_smm | nmi_en) & ~ev.acc & ~ev.rsm_any;
    nmi_src   = nmi_lat_q | nmi_edge;  // a second edge merges into the latch
    nmi_d     = nmi_src & nmi_ok;
    nmi_lat_d = nmi_src & ~nmi_ok;
    intr_d    = intr_lvl & if_q & ~ev.acc & ~nmi_d;
    if_save_d = ev.first_entry ? if_q : if_save_q;
    if (ev.acc)           if_d = 1'b0;
    else if (ev.exit_smm) if_d = if_save_q;
    else if (intr_d)      if_d = 1'b0;
    else if (if_set)      if_d = 1'b1;
    else                  if_d = if_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_lat_q <= 1'b0;
      if_q      <= 1'b0;
      if_save_q <= 1'b0;
      nmi_dlv   <= 1'b0;
      intr_dlv  <= 1'b0;
    end else begin
      nmi_lat_q <= nmi_lat_d;
      if_q      <= if_d;
      if_save_q <= if_save_d;
      nmi_dlv   <= nmi_d;
      intr_dlv  <= intr_d;
    end
  end
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SZ_W    = 5,
  parameter int DEPTH_W = 4,
  parameter int MIN_LOG = 12,
  parameter int MAX_LOG = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_req,
  input  logic              rsm,
  input  logic              nest_en,
  input  logic              nmi_edge,
  input  logic              nmi_en,
  input  logic              intr_lvl,
  input  logic              if_set,
  input  logic [ADDR_W-1:0] smm_base,
  input  logic [SZ_W-1:0]   size_log,
  output logic              cfg_err,
  output logic              in_smm,
  output logic              smi_ack,
  output logic [ADDR_W-1:0] smi_vec,
  output logic              nest_flag,
  output logic              nmi_dlv,
  output logic              intr_dlv
);
  smm_ev_t ev;

  smm_cfg_check #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)
  ) u_cfg (
    .smm_base(smm_base), .size_log(size_log), .cfg_err(cfg_err)
  );

  smm_nest_seq #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm(rsm),
    .nest_en(nest_en), .cfg_err(cfg_err), .smm_base(smm_base),
    .ev(ev), .in_smm(in_smm), .smi_ack(smi_ack), .smi_vec(smi_vec),
    .nest_flag(nest_flag)
  );

  smm_irq_gate u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .in_smm(in_smm),
    .nmi_edge(nmi_edge), .nmi_en(nmi_en), .intr_lvl(intr_lvl),
    .if_set(if_set), .nmi_dlv(nmi_dlv), .intr_dlv(intr_dlv)
  );
endmodule

// File: rtl/smm_ctrl_chk.sv
module smm_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nest_en,
  input logic              cfg_err,
  input logic              in_smm,
  input logic              smi_ack,
  input logic [ADDR_W-1:0] smi_vec,
  input logic [ADDR_W-1:0] smm_base,
  input logic              nest_flag,
  input logic              nmi_dlv,
  input logic              intr_dlv
);
  // R10
  no_ack_on_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !smi_ack);

  // R3
  no_ack_unnested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm && !nest_en) |=> !smi_ack);

  // R2
  ack_enters_smm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_ack |-> in_smm);

  // R2
  ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_ack |-> (smi_vec == $past(smm_base)));

  // R4
  nest_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_ack |-> (nest_flag == $past(in_smm)));

  // R13
  single_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_dlv, intr_dlv}));

  // R6
  no_intr_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(intr_dlv && smi_ack));
endmodule

bind smm_ctrl smm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nest_en(nest_en), .cfg_err(cfg_err),
  .in_smm(in_smm), .smi_ack(smi_ack), .smi_vec(smi_vec),
  .smm_base(smm_base), .nest_flag(nest_flag), .nmi_dlv(nmi_dlv),
  .intr_dlv(intr_dlv)
);

// File: tb/tb_smm_ctrl.sv
module tb_smm_ctrl;
  logic        clk, rst_n;
  logic        smi_req, rsm, nest_en, nmi_edge, nmi_en, intr_lvl, if_set;
  logic [31:0] smm_base;
  logic [4:0]  size_log;
  logic        cfg_err, in_smm, smi_ack, nest_flag, nmi_dlv, intr_dlv;
  logic [31:0] smi_vec;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  smm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm(rsm), .nest_en(nest_en),
    .nmi_edge(nmi_edge), .nmi_en(nmi_en), .intr_lvl(intr_lvl), .if_set(if_set),
    .smm_base(smm_base), .size_log(size_log), .cfg_err(cfg_err), .in_smm(in_smm),
    .smi_ack(smi_ack), .smi_vec(smi_vec), .nest_flag(nest_flag),
    .nmi_dlv(nmi_dlv), .intr_dlv(intr_dlv)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: inputs set before the edge, outputs sampled 2 ns after it.
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic strobe_clear();
    smi_req = 0; rsm = 0; nmi_edge = 0; if_set = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; strobe_clear();
    nest_en = 0; nmi_en = 0; intr_lvl = 0;
    smm_base = 32'h0003_8000; size_log = 5'd15;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cyc();
    // reset state
    chk("R2 reset in_smm", in_smm, 0);
    chk("R2 reset ack", smi_ack, 0);
    chk("R13 reset nmi", nmi_dlv, 0);
    chk("R6 reset intr", intr_dlv, 0);
    chk("R4 reset nest", nest_flag, 0);

    // R1 sweep over every size code and several bases
    for (int lg = 0; lg < 32; lg++) begin
      for (int b = 0; b < 6; b++) begin
        logic [31:0] bv;
        logic        e;
        case (b)
          0: bv = 32'h0;
          1: bv = 32'h1000;
          2: bv = 32'h8000;
          3: bv = 32'h38000;
          4: bv = 32'h2000000;
          default: bv = 32'h1234000;
        endcase
        smm_base = bv; size_log = lg[4:0];
        #1;
        e = (lg < 12) || (lg > 25) || ((64'(bv) % (64'd1 << lg)) != 0);
        chk("R1 cfg_err", cfg_err, e);
      end
    end
    smm_base = 32'h0003_8000; size_log = 5'd15;
    cyc();

    // R13 normal-mode NMI beats INTR
    if_set = 1; cyc(); strobe_clear();
    intr_lvl = 1; nmi_edge = 1; cyc(); strobe_clear();
    chk("R13 nmi first", nmi_dlv, 1);
    chk("R13 intr waits", intr_dlv, 0);
    cyc();
    chk("R13 intr next", intr_dlv, 1);
    cyc();
    chk("R6 flag cleared by take", intr_dlv, 0);
    if_set = 1; cyc(); strobe_clear();
    chk("R6 set effective later", intr_dlv, 0);
    cyc();
    chk("R6 intr after set", intr_dlv, 1);
    intr_lvl = 0;
    if_set = 1; cyc(); strobe_clear();  // flag = 1 before entry

    // R2 entry
    smi_req = 1; cyc(); strobe_clear();
    chk("R2 ack", smi_ack, 1);
    chk("R2 vec", smi_vec, 32'h0003_8000);
    chk("R2 in_smm", in_smm, 1);
    chk("R2 nest_flag", nest_flag, 0);
    cyc();
    chk("R2 ack pulse", smi_ack, 0);

    // R6 flag cleared on entry
    intr_lvl = 1; cyc(); cyc();
    chk("R6 intr masked in smm", intr_dlv, 0);
    if_set = 1; cyc(); strobe_clear();
    chk("R6 set same cycle", intr_dlv, 0);
    cyc();
    chk("R6 intr after set in smm", intr_dlv, 1);
    intr_lvl = 0; cyc();

    // R7 NMI latched, extra edge dropped
    nmi_edge = 1; cyc(); strobe_clear();
    chk("R7 nmi latched", nmi_dlv, 0);
    nmi_edge = 1; cyc(); strobe_clear();
    chk("R7 nmi still latched", nmi_dlv, 0);
    nmi_en = 1; cyc();
    chk("R7 nmi on enable", nmi_dlv, 1);
    cyc();
    chk("R8 single delivery", nmi_dlv, 0);
    nmi_en = 0;

    // R3 held SMI, R9 priority over latched NMI
    smi_req = 1; cyc(); strobe_clear();
    chk("R3 held no ack", smi_ack, 0);
    nmi_edge = 1; cyc(); strobe_clear();
    chk("R3 still held", smi_ack, 0);
    chk("R3 in smm", in_smm, 1);
    rsm = 1; cyc(); strobe_clear();
    chk("R5 exit", in_smm, 0);
    chk("R3 no ack on rsm", smi_ack, 0);
    chk("R9 no nmi on rsm", nmi_dlv, 0);
    cyc();
    chk("R3 held ack after exit", smi_ack, 1);
    chk("R9 nmi stays latched", nmi_dlv, 0);
    chk("R3 nest flag clear", nest_flag, 0);

    // R8 latched NMI released by exit; R12 flag restored
    rsm = 1; cyc(); strobe_clear();
    chk("R8 no nmi on rsm", nmi_dlv, 0);
    cyc();
    chk("R8 nmi after exit", nmi_dlv, 1);
    cyc();
    chk("R8 nmi once", nmi_dlv, 0);
    intr_lvl = 1; cyc();
    chk("R12 flag restored", intr_dlv, 1);
    intr_lvl = 0; cyc();

    // R4/R11/R5 nested entries up to depth 15
    nest_en = 1;
    smi_req = 1; cyc(); strobe_clear();
    chk("R4 outer ack", smi_ack, 1);
    chk("R4 outer flag", nest_flag, 0);
    for (int k = 2; k <= 15; k++) begin
      smi_req = 1; cyc(); strobe_clear();
      chk("R4 nested ack", smi_ack, 1);
      chk("R4 nested flag", nest_flag, 1);
    end
    smi_req = 1; cyc(); strobe_clear();
    chk("R11 full no ack", smi_ack, 0);
    cyc();
    chk("R11 still held", smi_ack, 0);
    rsm = 1; cyc(); strobe_clear();
    chk("R11 no ack on rsm", smi_ack, 0);
    cyc();
    chk("R11 held accepted", smi_ack, 1);
    chk("R11 nested flag", nest_flag, 1);
    for (int k = 15; k >= 2; k--) begin
      rsm = 1; cyc(); strobe_clear();
      chk("R5 stays in smm", in_smm, 1);
    end
    rsm = 1; cyc(); strobe_clear();
    chk("R5 last exit", in_smm, 0);

    // R10 illegal config holds request
    size_log = 5'd11;
    smi_req = 1; cyc(); strobe_clear();
    chk("R10 no ack bad cfg", smi_ack, 0);
    cyc();
    chk("R10 still held", smi_ack, 0);
    chk("R10 not in smm", in_smm, 0);
    size_log = 5'd15; cyc();
    chk("R10 ack after fix", smi_ack, 1);
    chk("R10 vec", smi_vec, 32'h0003_8000);
    rsm = 1; cyc(); strobe_clear();
    chk("R5 exit after fix", in_smm, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule